// File: doc/BRIEF.md
# Serial Audio Source Selector

This block takes two serial stereo audio streams, one from a digital audio receiver and one from an analog-to-digital converter. Each stream has its own bit clock, frame sync and data line, and carries one 64-bit string per stereo frame. The block assembles complete frames from both streams and passes the frames of one stream downstream to a level meter as parallel left and right sample words with a one-cycle valid strobe.

The receiver's lock indication picks the stream. While the receiver is locked, its frames are used even when its error flag is set. While it is unlocked, the converter stream is used, even when that converter is absent or silent. The selection changes only when a whole frame of the newly chosen stream completes, so an output sample never holds bits from both streams. Every completed receiver frame latches three receiver flags into a status register, which is read at address zero.

The block also drives a reset line that starts the converter's self-calibration. The reset repeats once per parameterised period, which defaults to one day of clock cycles. While the reset and the calibration time that follows it are running, converter samples are output as zero.

Top module: `audio_src_sel`

## Requirements
- R1: A frame begins at the bit clock rise where frame sync is high. Bits arrive MSB first, 64 per frame. The first 32-bit slot is the left channel and the second is the right. Each output word is the upper 24 bits of its slot, and the low 8 bits of each slot are discarded.
- R2: While `rx_lock_i` is high, each completed receiver frame is output with `src_adc_o` = 0, whatever the level of `rx_err_i`.
- R3: While `rx_lock_i` is low, each completed converter frame is output with `src_adc_o` = 1, and completed receiver frames produce no strobe.
- R4: A completed frame from the stream not selected produces no strobe. `src_adc_o` changes only in a cycle where `valid_o` is high.
- R5: `valid_o` is high for exactly one cycle. That cycle is the fourth clock cycle after the 64th bit clock rise is presented at the inputs.
- R6: Each completed receiver frame latches the status flags, with lock not taken into account: bit 0 is `rx_cs_i`, bit 1 is `rx_blk_i` and bit 2 is `rx_err_i`. The flags are sampled in the cycle the frame completes.
- R7: When `reg_addr_i` is 0, `reg_rdata_o` returns the latched flags in bits 2:0 with the upper bits zero. Any other address reads zero.
- R8: The clock-cycle phase counter starts at 0 on reset and wraps after `CAL_PERIOD` cycles. `adc_rst_o` is high while the phase is below `RST_CYC`.
- R9: A converter-sourced sample is output as zero in both channels when the phase, in the cycle the strobe is registered, is below `RST_CYC + CAL_CYC`. Receiver-sourced samples are never zeroed.
- R10: A frame sync in the middle of a frame discards the partial frame and restarts assembly.
- R11: After reset: `valid_o` = 0, `left_o` = `right_o` = 0, `src_adc_o` = 1, status flags = 0, and `adc_rst_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_sclk_i | input | 1 | Receiver stream bit clock |
| rx_fs_i | input | 1 | Receiver stream frame sync |
| rx_sd_i | input | 1 | Receiver stream serial data |
| rx_lock_i | input | 1 | Receiver lock indication |
| rx_cs_i | input | 1 | Receiver channel status bit |
| rx_blk_i | input | 1 | Receiver start-of-subcode-block flag |
| rx_err_i | input | 1 | Receiver error flag |
| adc_sclk_i | input | 1 | Converter stream bit clock |
| adc_fs_i | input | 1 | Converter stream frame sync |
| adc_sd_i | input | 1 | Converter stream serial data |
| reg_addr_i | input | ADDR_W | Status read address |
| reg_rdata_o | output | DATA_W | Status read data |
| left_o | output | SAMPLE_W | Left sample word |
| right_o | output | SAMPLE_W | Right sample word |
| valid_o | output | 1 | One-cycle sample strobe |
| src_adc_o | output | 1 | 1 when the converter stream is selected |
| adc_rst_o | output | 1 | Converter calibration reset |

## Verification
The serial inputs pass through two synchroniser stages, then an edge register, and then the frame register and the output register. As a result, a sample strobe is due exactly four clock cycles after the final bit clock rise. The status flags and `src_adc_o` update in that same cycle. The bench drives each input just after a falling clock edge and samples at the third, fourth and fifth falling edges after the final rise. It expects the strobe only at the fourth. `adc_rst_o` and the mute window follow a phase count that equals the number of rising edges since reset release, modulo the period. The bench keeps its own rising-edge counter and compares `adc_rst_o` with that count at every falling edge. For a strobe seen after k rising edges, it predicts muting from phase k-1, because the output register sampled the phase one edge earlier.

// File: rtl/asrc_pkg.sv
package asrc_pkg;
  typedef enum logic {SRC_RX = 1'b0, SRC_ADC = 1'b1} src_e;

  typedef struct packed {
    logic err;
    logic blk;
    logic cs;
  } rx_stat_t;
endpackage

// File: rtl/asrc_deser.sv
module asrc_deser #(
  parameter int unsigned FRAME_BITS = 64,
  parameter int unsigned SLOT_BITS  = 32,
  parameter int unsigned SAMPLE_W   = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                fs_i,
  input  logic                sd_i,
  output logic                done_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam int unsigned PAD   = SLOT_BITS - SAMPLE_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);

  logic [2:0]            sclk_q;
  logic [1:0]            fs_q, sd_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-2:0] sh_q;
  logic [FRAME_BITS-1:0] word;
  logic                  rise;
  logic                  unused_pad;

  assign rise = sclk_q[1] & ~sclk_q[2];
  assign word = {sh_q, sd_q[1]};
  assign unused_pad = ^{word[SLOT_BITS+PAD-1:SLOT_BITS], word[PAD-1:0]};

  // two-stage synchroniser, third stage of sclk for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      fs_q   <= '0;
      sd_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      fs_q   <= {fs_q[0], fs_i};
      sd_q   <= {sd_q[0], sd_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      done_o  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (rise) begin
        sh_q <= word[FRAME_BITS-2:0];
        if (fs_q[1]) begin
          cnt_q <= CNT_W'(1);
        end else if (cnt_q != '0 && cnt_q < FULL) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            done_o  <= 1'b1;
            left_o  <= word[FRAME_BITS-1 -: SAMPLE_W];
            right_o <= word[SLOT_BITS-1 -: SAMPLE_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/asrc_cal_timer.sv
module asrc_cal_timer #(
  parameter longint unsigned CAL_PERIOD = 64'd17280000000000,
  parameter int unsigned     RST_CYC    = 200,
  parameter int unsigned     CAL_CYC    = 100000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic adc_rst_o,
  output logic mute_o
);
  localparam int unsigned CNT_W = $clog2(CAL_PERIOD);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(CAL_PERIOD - 1);
  localparam logic [CNT_W-1:0] RST_END  = CNT_W'(RST_CYC);
  localparam logic [CNT_W-1:0] MUTE_END = CNT_W'(longint'(RST_CYC) + longint'(CAL_CYC));

  logic [CNT_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign adc_rst_o = phase_q < RST_END;
  assign mute_o    = phase_q < MUTE_END;
endmodule

// File: rtl/asrc_status.sv
module asrc_status
  import asrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  rx_stat_t          flags_i,
  input  logic [ADDR_W-1:0] addr_i,
  output rx_stat_t          stat_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_o <= '0;
    else if (latch_i) stat_o <= flags_i;
  end

  assign rdata_o = (addr_i == '0) ? DATA_W'(stat_o) : '0;
endmodule

// File: rtl/audio_src_sel.sv
module audio_src_sel
  import asrc_pkg::*;
#(
  parameter int unsigned     FRAME_BITS = 64,
  parameter int unsigned     SLOT_BITS  = 32,
  parameter int unsigned     SAMPLE_W   = 24,
  parameter int unsigned     ADDR_W     = 4,
  parameter int unsigned     DATA_W     = 8,
  parameter longint unsigned CAL_PERIOD = 64'd17280000000000,
  parameter int unsigned     RST_CYC    = 200,
  parameter int unsigned     CAL_CYC    = 100000000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_sclk_i,
  input  logic                rx_fs_i,
  input  logic                rx_sd_i,
  input  logic                rx_lock_i,
  input  logic                rx_cs_i,
  input  logic                rx_blk_i,
  input  logic                rx_err_i,
  input  logic                adc_sclk_i,
  input  logic                adc_fs_i,
  input  logic                adc_sd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                src_adc_o,
  output logic                adc_rst_o
);
  localparam int unsigned N_SRC = 2;

  logic [N_SRC-1:0]    sclk_v, fs_v, sd_v, done_v;
  logic [SAMPLE_W-1:0] l_v [N_SRC];
  logic [SAMPLE_W-1:0] r_v [N_SRC];
  logic                lock_q;
  logic                cal_mute;
  rx_stat_t            flags, stat_q;

  assign sclk_v = {adc_sclk_i, rx_sclk_i};
  assign fs_v   = {adc_fs_i,   rx_fs_i};
  assign sd_v   = {adc_sd_i,   rx_sd_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    asrc_deser #(
      .FRAME_BITS(FRAME_BITS),
      .SLOT_BITS (SLOT_BITS),
      .SAMPLE_W  (SAMPLE_W)
    ) u_des (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sclk_i (sclk_v[g]),
      .fs_i   (fs_v[g]),
      .sd_i   (sd_v[g]),
      .done_o (done_v[g]),
      .left_o (l_v[g]),
      .right_o(r_v[g])
    );
  end

  asrc_cal_timer #(
    .CAL_PERIOD(CAL_PERIOD),
    .RST_CYC   (RST_CYC),
    .CAL_CYC   (CAL_CYC)
  ) u_cal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adc_rst_o(adc_rst_o),
    .mute_o   (cal_mute)
  );

  assign flags = '{err: rx_err_i, blk: rx_blk_i, cs: rx_cs_i};

  asrc_status #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .latch_i(done_v[SRC_RX]),
    .flags_i(flags),
    .addr_i (reg_addr_i),
    .stat_o (stat_q),
    .rdata_o(reg_rdata_o)
  );

  // error flag deliberately not part of the choice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b0;
      valid_o   <= 1'b0;
      src_adc_o <= 1'b1;
      left_o    <= '0;
      right_o   <= '0;
    end else begin
      lock_q  <= rx_lock_i;
      valid_o <= 1'b0;
      if (lock_q && done_v[SRC_RX]) begin
        valid_o   <= 1'b1;
        src_adc_o <= 1'b0;
        left_o    <= l_v[SRC_RX];
        right_o   <= r_v[SRC_RX];
      end else if (!lock_q && done_v[SRC_ADC]) begin
        valid_o   <= 1'b1;
        src_adc_o <= 1'b1;
        left_o    <= cal_mute ? '0 : l_v[SRC_ADC];
        right_o   <= cal_mute ? '0 : r_v[SRC_ADC];
      end
    end
  end
endmodule

// File: rtl/asrc_chk.sv
module asrc_chk #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                src_adc_i,
  input logic                lock_q_i,
  input logic                mute_i,
  input logic                adc_rst_i,
  input logic [SAMPLE_W-1:0] left_i,
  input logic [SAMPLE_W-1:0] right_i,
  input logic                rx_done_i,
  input logic [2:0]          flags_i,
  input logic [2:0]          stat_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [DATA_W-1:0]   reg_rdata_i
);
  // R2 R3
  sel_follows_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (src_adc_i == !$past(lock_q_i)));

  // R4
  src_change_on_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_adc_i) |-> valid_i);

  // R5
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R6
  stat_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> (stat_i == $past(flags_i)));

  // R7
  rd_other_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != '0) |-> (reg_rdata_i == '0));

  // R8
  rst_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_rst_i |-> mute_i);

  // R9
  mute_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_adc_i && $past(mute_i)) |-> (left_i == '0 && right_i == '0));
endmodule

bind audio_src_sel asrc_chk #(
  .SAMPLE_W(SAMPLE_W),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_o),
  .src_adc_i  (src_adc_o),
  .lock_q_i   (lock_q),
  .mute_i     (cal_mute),
  .adc_rst_i  (adc_rst_o),
  .left_i     (left_o),
  .right_i    (right_o),
  .rx_done_i  (done_v[0]),
  .flags_i    ({rx_err_i, rx_blk_i, rx_cs_i}),
  .stat_i     (stat_q),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_i(reg_rdata_o)
);

// File: tb/audio_src_sel_test.sv
`timescale 1ns/1ps
module audio_src_sel_test;
  localparam int unsigned SW  = 24;
  localparam int unsigned P   = 4000;
  localparam int unsigned RST = 10;
  localparam int unsigned CAL = 300;

  typedef struct packed {
    logic          lock;
    logic          use_adc;
    logic [SW-1:0] l;
    logic [SW-1:0] r;
    logic          cs;
    logic          blk;
    logic          err;
    logic          exp_valid;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 24'h123456, 24'hABCDEF, 1'b0, 1'b0, 1'b0, 1'b1}, // R3, muted R9
    '{1'b0, 1'b0, 24'h111111, 24'h222222, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 rx ignored
    '{1'b1, 1'b0, 24'hC0FFEE, 24'h0BADF0, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 err set
    '{1'b1, 1'b1, 24'h333333, 24'h444444, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 adc ignored
    '{1'b1, 1'b0, 24'h800001, 24'h7FFFFE, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 24'h7FFFFF, 24'h800000, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 24'hFFFFFF, 24'h000001, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 24'h000000, 24'hFFFFFF, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_sclk = 0, rx_fs = 0, rx_sd = 0, rx_lock = 0, rx_cs = 0, rx_blk = 0, rx_err = 0;
  logic adc_sclk = 0, adc_fs = 0, adc_sd = 0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_rdata;
  logic [SW-1:0] left_o, right_o;
  logic valid_o, src_adc_o, adc_rst_o;

  int n_chk = 0, n_fail = 0;
  int unsigned pcnt = 0;
  int rst_bad = 0;
  bit finished = 0;
  logic v3, v4, v5, cap_src;
  logic [SW-1:0] cap_l, cap_r;
  int unsigned cap_k;

  always #2.5 clk = ~clk;

  audio_src_sel #(
    .CAL_PERIOD(P), .RST_CYC(RST), .CAL_CYC(CAL)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_sclk_i(rx_sclk), .rx_fs_i(rx_fs), .rx_sd_i(rx_sd), .rx_lock_i(rx_lock),
    .rx_cs_i(rx_cs), .rx_blk_i(rx_blk), .rx_err_i(rx_err),
    .adc_sclk_i(adc_sclk), .adc_fs_i(adc_fs), .adc_sd_i(adc_sd),
    .reg_addr_i(reg_addr), .reg_rdata_o(reg_rdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .src_adc_o(src_adc_o), .adc_rst_o(adc_rst_o)
  );

  always @(posedge clk) begin
    if (!rst_ni) pcnt <= 0;
    else         pcnt <= pcnt + 1;
  end

  // R8 phase model checked every cycle
  always @(negedge clk) begin
    if (rst_ni && !finished && (adc_rst_o !== ((pcnt % P) < RST))) begin
      if (rst_bad == 0)
        $display("FAIL R8 adc_rst_o=%0b expected %0b at phase %0d", adc_rst_o, !adc_rst_o, pcnt % P);
      rst_bad++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit adc, input bit sclk, input bit fs, input bit sd);
    if (adc) begin adc_sclk = sclk; adc_fs = fs; adc_sd = sd; end
    else     begin rx_sclk = sclk;  rx_fs = fs;  rx_sd = sd;  end
  endtask

  // sends nbits of a 64-bit word; captures output around R5 window
  task automatic send(input bit adc, input logic [63:0] w, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk); drive(adc, 0, b == 0, w[63-b]);
      @(negedge clk);
      @(negedge clk); drive(adc, 1, b == 0, w[63-b]);
      if (b != nbits - 1) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    v3 = valid_o;
    @(negedge clk);
    v4 = valid_o; cap_l = left_o; cap_r = right_o; cap_src = src_adc_o; cap_k = pcnt;
    @(negedge clk);
    v5 = valid_o;
    drive(adc, 0, 0, 0);
  endtask

  function automatic logic [63:0] mk(input logic [SW-1:0] l, input logic [SW-1:0] r);
    return {l, 8'h5A, r, 8'hA5};
  endfunction

  function automatic bit muted_at(input int unsigned k);
    return ((k - 1) % P) < (RST + CAL);
  endfunction

  task automatic wait_phase(input int unsigned ph);
    while ((pcnt % P) != ph) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog expired actual=running expected=done");
    n_chk++; n_fail++;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic prev_src;
    logic [SW-1:0] el, er;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", {31'b0, valid_o}, 0);
    check("R11 left/right", {8'b0, left_o ^ right_o}, 0);
    check("R11 src_adc", {31'b0, src_adc_o}, 1);
    check("R11 stat", {24'b0, reg_rdata}, 0);
    check("R11 adc_rst", {31'b0, adc_rst_o}, 1);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      rx_lock = v.lock; rx_cs = v.cs; rx_blk = v.blk; rx_err = v.err;
      prev_src = src_adc_o;
      send(v.use_adc, mk(v.l, v.r), 64);
      check($sformatf("R5 v%0d strobe before", i), {31'b0, v3}, 0);
      check($sformatf("R4 v%0d strobe", i), {31'b0, v4}, {31'b0, v.exp_valid});
      check($sformatf("R5 v%0d strobe after", i), {31'b0, v5}, 0);
      if (v.exp_valid) begin
        el = (v.use_adc && muted_at(cap_k)) ? '0 : v.l;
        er = (v.use_adc && muted_at(cap_k)) ? '0 : v.r;
        check($sformatf("R2 R3 v%0d src", i), {31'b0, cap_src}, {31'b0, v.use_adc});
        check($sformatf("R1 R9 v%0d left", i), {8'b0, cap_l}, {8'b0, el});
        check($sformatf("R1 R9 v%0d right", i), {8'b0, cap_r}, {8'b0, er});
      end else begin
        check($sformatf("R4 v%0d src held", i), {31'b0, src_adc_o}, {31'b0, prev_src});
      end
      if (!v.use_adc)
        check($sformatf("R6 R7 v%0d stat", i), {24'b0, reg_rdata}, {29'b0, v.err, v.blk, v.cs});
    end

    // R7 other address
    reg_addr = 4'd1;
    @(negedge clk);
    check("R7 addr1", {24'b0, reg_rdata}, 0);
    reg_addr = 4'd0;

    // R10 aborted frame then full frame
    rx_lock = 0;
    send(1, mk(24'hDEAD00, 24'hBEEF00), 20);
    check("R10 partial no strobe", {31'b0, v4}, 0);
    send(1, mk(24'h5A5A5A, 24'hA5A5A5), 64);
    check("R10 src", {31'b0, cap_src}, 1);
    check("R10 left", {8'b0, cap_l}, {8'b0, muted_at(cap_k) ? 24'h0 : 24'h5A5A5A});

    // R9 receiver not muted inside the window
    rx_lock = 1;
    wait_phase(P - 100);
    send(0, mk(24'h13579B, 24'h2468AC), 64);
    check("R9 rx in window phase", {31'b0, muted_at(cap_k)}, 1);
    check("R9 rx left", {8'b0, cap_l}, {8'b0, 24'h13579B});
    check("R9 rx right", {8'b0, cap_r}, {8'b0, 24'h2468AC});

    // R9 converter muted inside the window
    rx_lock = 0;
    wait_phase(P - 100);
    send(1, mk(24'h13579B, 24'h2468AC), 64);
    check("R9 adc strobe", {31'b0, v4}, 1);
    check("R9 adc left zero", {8'b0, cap_l}, 0);
    check("R9 adc right zero", {8'b0, cap_r}, 0);

    // R9 converter passes once window ends
    wait_phase(RST + CAL + 50);
    send(1, mk(24'h0F0F0F, 24'hF0F0F0), 64);
    check("R9 adc after window", {8'b0, cap_l}, {8'b0, 24'h0F0F0F});

    check("R8 adc_rst mismatches", rst_bad, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule